// File: doc/BRIEF.md
# SPI Command Decoder Slave

This block is a serial-peripheral slave that lives inside a larger chip. It takes byte commands from a host controller. All of SCK, MOSI and the active-low select are brought into the system clock through two-flop synchronisers. Edges of SCK are found in the system clock domain. The link runs in mode 0 and sends the most significant bit first.

Every assertion of the select opens a new frame. The first byte of a frame is an opcode, and any bytes after it are operands. The block holds two registers. The first is a 4-bit mapper register, which an opcode writes from its own low nibble. The second is a 24-bit address register, which a set-address opcode loads from three operand bytes. A test opcode makes the block shift a fixed signature byte out on MISO while the host clocks the third byte of the frame. Opcodes that fall outside these three kinds leave all state as it was.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, mapper reads 0, address reads 0 and MISO is low.
- R2: The mapper opcode is any byte whose bits [7:4] equal 0x3. It copies its bits [3:0] into mapper when it completes as the first byte of a frame, and it takes no operands. Later bytes in the same frame do not change mapper.
- R3: Opcode 0x00 followed by three operand bytes sets address to {op1, op2, op3}, with op1 in bits [23:16]. A bank number N carried as N*0x20 in op1 therefore lands in address[23:21]. The address register changes only when the third operand byte completes.
- R4: Opcode 0xF0 makes MISO carry the SIGNATURE byte (default 0xA5), MSB first, during the third byte of the frame. Each bit is presented after a falling SCK edge, so the host reads it on the following rising edge. The second byte is a dummy.
- R5: MISO is low during every byte other than the response byte of a test frame, and it is low while select is high.
- R6: When select rises, the frame ends and any partial byte is discarded. The first full byte after select falls again is decoded as an opcode.
- R7: Any opcode that is not 0x00, not 0xF0 and not in the 0x3 group leaves mapper and address unchanged and drives no response.
- R8: Bytes after the third address operand within the same frame are ignored, and address keeps the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host, asynchronous |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low frame select from the host |
| miso | output | 1 | Serial data to the host |
| mapper | output | 4 | Mapper register |
| address | output | 24 | Address register |

## Verification
The embedded properties assume that each SCK phase lasts several system clocks. Under that assumption, a rising and a falling edge are never detected in the same cycle, and the synchronised MOSI bit is settled when a rising edge is seen. They also assume that select changes only while SCK is low. The bench holds every SCK half-period at six system clocks and moves MOSI and select only during the low phase. It also keeps select high for at least two half-periods between frames, so each frame starts from a clean bit and byte count.

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter logic [7:0] SIGNATURE  = 8'hA5,
  parameter logic [3:0] MAP_GROUP  = 4'h3,
  parameter logic [7:0] ADDR_OP    = 8'h00,
  parameter logic [7:0] TEST_OP    = 8'hF0,
  parameter int         ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sck,
  input  logic                    mosi,
  input  logic                    cs_n,
  output logic                    miso,
  output logic [3:0]              mapper,
  output logic [8*ADDR_BYTES-1:0] address
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int IW = $clog2(ADDR_BYTES + 2);
  localparam logic [IW-1:0] LAST_IDX = IW'(ADDR_BYTES);
  localparam logic [IW-1:0] SAT_IDX  = IW'(ADDR_BYTES + 1);
  localparam logic [IW-1:0] RESP_IDX = IW'(2);

  logic [2:0] sck_q;
  logic [1:0] mosi_q, cs_q;
  logic [2:0] bit_cnt;
  logic [IW-1:0] idx;
  logic [6:0] shreg;
  logic [7:0] opcode;
  logic [ADDR_W-9:0] acc;
  logic miso_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      cs_q   <= 2'b11;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
      cs_q   <= {cs_q[0], cs_n};
    end
  end

  wire idle     = cs_q[1];
  wire rise     = sck_q[1] & ~sck_q[2];
  wire fall     = ~sck_q[1] & sck_q[2];
  wire byte_end = rise & ~idle & (bit_cnt == 3'd7);
  wire [7:0] rx_byte = {shreg, mosi_q[1]};
  wire addr_frame = (opcode == ADDR_OP) && (idx != '0) && (idx != SAT_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      idx     <= '0;
      shreg   <= '0;
      opcode  <= '0;
      acc     <= '0;
      mapper  <= '0;
      address <= '0;
      miso_r  <= 1'b0;
    end else if (idle) begin
      bit_cnt <= '0;
      idx     <= '0;
      miso_r  <= 1'b0;
    end else begin
      if (rise) begin
        shreg   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_end) begin
        if (idx != SAT_IDX) idx <= idx + 1'b1;
        if (idx == '0) begin
          opcode <= rx_byte;
          if (rx_byte[7:4] == MAP_GROUP) mapper <= rx_byte[3:0];
        end else if (addr_frame) begin
          acc <= {acc, rx_byte} >> 0;
          if (idx == LAST_IDX) address <= {acc, rx_byte};
        end
      end
      if (fall)
        miso_r <= (opcode == TEST_OP && idx == RESP_IDX) ? SIGNATURE[~bit_cnt] : 1'b0;
    end
  end

  assign miso = miso_r;

  // R5
  miso_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle) |-> !miso);

  // R6
  frame_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle) |-> (bit_cnt == 3'd0 && idx == '0));

  // R2
  mapper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_end && idx == '0) |-> $stable(mapper));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_end && idx == LAST_IDX) |-> $stable(address));

  // R4
  miso_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(fall) && !$past(idle)) |-> $stable(miso));

  // R8
  idx_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(idx) == SAT_IDX && !$past(idle)) |-> (idx == SAT_IDX));
endmodule

// File: tb/sim_spi_cmd_slave.sv
module sim_spi_cmd_slave;
  localparam int H = 6;
  localparam logic [7:0] SIG = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso;
  logic [3:0] mapper;
  logic [23:0] address;
  int n_chk = 0, n_fail = 0;
  logic [3:0] exp_map = '0;
  logic [23:0] exp_addr = '0;

  always #10 clk = ~clk;

  spi_cmd_slave u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
                    .miso(miso), .mapper(mapper), .address(address));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nbits; b--) begin
      mosi = tx[b];
      half();
      rx[b] = miso;
      sck = 1'b1;
      half();
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    send_bits(tx, 8, rx);
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    half();
  endtask

  task automatic close_frame();
    half();
    cs_n = 1'b1;
    half();
    half();
  endtask

  task automatic check_regs(input string req);
    check(mapper == exp_map, req, {28'd0, mapper}, {28'd0, exp_map});
    check(address == exp_addr, req, {8'd0, address}, {8'd0, exp_addr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mapper == 4'h0, "R1", {28'd0, mapper}, 0);
    check(address == 24'h0, "R1", {8'd0, address}, 0);
    check(miso == 1'b0, "R1", {31'd0, miso}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 all mapper values, trailing bytes ignored
    for (int v = 0; v < 16; v++) begin
      open_frame();
      xfer(8'h30 | 8'(v), rx);
      exp_map = 4'(v);
      xfer(8'h3F - 8'(v), rx);
      close_frame();
      check_regs("R2");
    end

    // R3 bank sweep with varied low bytes
    for (int bk = 0; bk < 8; bk++) begin
      logic [7:0] b1, b2, b3;
      b1 = 8'(bk * 32);
      b2 = 8'(bk * 37 + 5);
      b3 = 8'(255 - bk * 19);
      open_frame();
      xfer(8'h00, rx);
      xfer(b1, rx);
      xfer(b2, rx);
      check_regs("R3 before third operand");
      xfer(b3, rx);
      close_frame();
      exp_addr = {b1, b2, b3};
      check_regs("R3");
      check(address[23:21] == 3'(bk), "R3 bank", {29'd0, address[23:21]}, bk);
    end

    // R8 extra bytes after address load
    open_frame();
    xfer(8'h00, rx); xfer(8'h12, rx); xfer(8'h34, rx); xfer(8'h56, rx);
    xfer(8'h9A, rx); xfer(8'hBC, rx); xfer(8'hDE, rx); xfer(8'hF1, rx);
    close_frame();
    exp_addr = 24'h123456;
    check_regs("R8");

    // R4 / R5 test command
    for (int t = 0; t < 3; t++) begin
      open_frame();
      xfer(8'hF0, rx);
      check(rx == 8'h00, "R5 opcode byte", rx, 0);
      xfer(8'h00, rx);
      check(rx == 8'h00, "R5 dummy byte", rx, 0);
      xfer(8'h00, rx);
      check(rx == SIG, "R4", rx, SIG);
      xfer(8'h00, rx);
      check(rx == 8'h00, "R5 trailing byte", rx, 0);
      close_frame();
      check(miso == 1'b0, "R5 idle", {31'd0, miso}, 0);
      check_regs("R4 no side effect");
    end

    // R6 abort mid-address: partial operand discarded
    open_frame();
    xfer(8'h00, rx); xfer(8'hAA, rx); xfer(8'hBB, rx);
    send_bits(8'hCC, 4, rx);
    close_frame();
    check_regs("R6 aborted load");
    // R6 abort mid-opcode, next frame decodes fresh opcode
    open_frame();
    send_bits(8'h00, 5, rx);
    close_frame();
    open_frame();
    xfer(8'h3C, rx);
    close_frame();
    exp_map = 4'hC;
    check_regs("R6 new opcode");
    open_frame();
    xfer(8'h00, rx); xfer(8'h01, rx); xfer(8'h02, rx); xfer(8'h03, rx);
    close_frame();
    exp_addr = 24'h010203;
    check_regs("R6 reopened frame");

    // R7 every other opcode ignored
    for (int op = 0; op < 256; op++) begin
      if (op == 8'h00 || op == 8'hF0 || op[7:4] == 4'h3) continue;
      open_frame();
      xfer(8'(op), rx);
      xfer(8'h00, rx);
      xfer(8'h00, rx);
      check(rx == 8'h00, "R7 no response", rx, 0);
      close_frame();
      check_regs("R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule